// File: doc/BRIEF.md
# Disk Sector Write Sequencer

This block runs the write of one complete disk sector. A write request is taken only while the block is idle, and only in the same cycle that a sector mark is present. Starting on that cycle the block drives the write gate to the head. It then starts an external field writer three times in a row: first for the header record, then for the label record, and last for the data record. For each field it gives the field writer the record kind and the word count. The field writer adds its own checksum and trailing zero words. The block moves to the next record when the field writer reports done. After the data field reports done, the block drops the write gate.

A sector mark works as a safety stop. If the next sector mark arrives while any field is still pending, the sector has taken too long. In that case the block aborts the field writer, drops the write gate, sets a sticky overrun flag and returns to idle. The overrun flag stays set until the next accepted request.

Top module: `sector_write_seq`

## Requirements
- R1: After reset, `write_gate`, `overrun`, `sector_done`, `fld_start` and `fld_abort` are all 0.
- R2: A request is accepted only in a cycle where `wr_req` and `sector_mark` are both high and the block is idle. `write_gate` is high from the next cycle on. A request without a sector mark, or a sector mark without a request, leaves `write_gate` low.
- R3: In each sector, `fld_start` pulses for exactly one cycle per record, while `write_gate` is high. The records come in a fixed order, shown on `fld_kind` during the pulse: 0 = header, then 1 = label, then 2 = data. The first pulse comes in the cycle after acceptance.
- R4: During each `fld_start` pulse, `fld_words` shows the length of that record: 2 for the header, `LBL_WORDS` (default 8) for the label, and 256 for the data record.
- R5: A `fld_done` pulse for a header or label field causes the next `fld_start` pulse in the following cycle.
- R6: A `fld_done` pulse for the data field makes `write_gate` low from the next cycle. In that same next cycle, `sector_done` pulses for one cycle. With a field writer latency of L cycles, `write_gate` is high for exactly 3(L+1) cycles.
- R7: A `sector_mark` in any cycle after acceptance, while the sector is still being written, raises `fld_abort` in that same cycle. `write_gate` is then low from the next cycle, `overrun` becomes 1, and `sector_done` does not pulse. A mark in the same cycle as the data field's `fld_done` also counts as an abort.
- R8: `overrun` holds its value until the next accepted request, and it reads 0 in the first cycle that `write_gate` is high.
- R9: If `wr_req` stays high during a sector write, it has no effect: the count of write-gate cycles and the sequence of record starts stay the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Sector write request |
| sector_mark | input | 1 | Sector mark pulse from the disk |
| fld_done | input | 1 | Field writer finished the current field |
| fld_start | output | 1 | Start the field writer for one record |
| fld_abort | output | 1 | Stop the field writer at once |
| fld_kind | output | 2 | Record kind: 0 header, 1 label, 2 data |
| fld_words | output | LEN_W (9 by default) | Word count of the current record |
| write_gate | output | 1 | Write enable to the head |
| overrun | output | 1 | Sticky flag: the last write was cut off by a sector mark |
| sector_done | output | 1 | One-cycle pulse when a sector write completes |

## Verification
The bench builds the block with a label length of 5 words instead of 8. This shows that `fld_words` follows the parameter. The header (2) and data (256) lengths keep their defaults. A behavioural field writer with a latency that the bench can set produces the done pulses. This keeps whole sectors short, so writes can finish normally, and sector marks can land at chosen offsets. The offsets tested include the very first cycle of a write and the exact cycle of the final done.

// File: rtl/sws_pkg.sv
package sws_pkg;

  typedef enum logic [1:0] {
    REC_HDR = 2'd0,
    REC_LBL = 2'd1,
    REC_DAT = 2'd2
  } rec_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } st_e;

  localparam int NUM_REC = 3;

  // Word count of a record given the three configured lengths.
  function automatic int unsigned rec_len(rec_e r, int unsigned hdr,
                                          int unsigned lbl, int unsigned dat);
    case (r)
      REC_HDR: return hdr;
      REC_LBL: return lbl;
      default: return dat;
    endcase
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b,
                                       int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sws_fsm.sv
module sws_fsm
  import sws_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic abort_evt,
  input  logic adv,
  input  logic fin,
  output logic st_start,
  output logic st_wait,
  output logic st_idle
);

  st_e state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (accept) state_nx = ST_START;
      ST_START: state_nx = abort_evt ? ST_IDLE : ST_WAIT;
      ST_WAIT: begin
        if (abort_evt || fin) state_nx = ST_IDLE;
        else if (adv)         state_nx = ST_START;
      end
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign st_start = (state == ST_START);
  assign st_wait  = (state == ST_WAIT);
  assign st_idle  = (state == ST_IDLE);

endmodule

// File: rtl/sws_rec_sel.sv
module sws_rec_sel #(
  parameter int NREC  = 3,
  localparam int IDX_W = (NREC > 1) ? $clog2(NREC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             last_rec
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) idx <= '0;
    else if (adv)      idx <= idx + 1'b1;
  end

  assign last_rec = (idx == IDX_W'(NREC - 1));

endmodule

// File: rtl/sws_status.sv
module sws_status (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic abort_evt,
  input  logic fin,
  output logic write_gate,
  output logic overrun,
  output logic sector_done
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      write_gate  <= 1'b0;
      overrun     <= 1'b0;
      sector_done <= 1'b0;
    end else begin
      sector_done <= fin;
      if (accept)                write_gate <= 1'b1;
      else if (abort_evt || fin) write_gate <= 1'b0;
      if (accept)                overrun <= 1'b0;
      else if (abort_evt)        overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/sector_write_seq.sv
module sector_write_seq
  import sws_pkg::*;
#(
  parameter int HDR_WORDS = 2,
  parameter int LBL_WORDS = 8,
  parameter int DAT_WORDS = 256,
  localparam int LEN_W = $clog2(max3(HDR_WORDS, LBL_WORDS, DAT_WORDS) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             sector_mark,
  input  logic             fld_done,
  output logic             fld_start,
  output logic             fld_abort,
  output logic [1:0]       fld_kind,
  output logic [LEN_W-1:0] fld_words,
  output logic             write_gate,
  output logic             overrun,
  output logic             sector_done
);

  localparam int IDX_W = $clog2(NUM_REC);

  logic st_start, st_wait, st_idle;
  logic accept, abort_evt, adv, fin, last_rec;
  logic [IDX_W-1:0] rec_idx;
  rec_e cur_rec;

  // Named internal events.
  assign accept    = st_idle && wr_req && sector_mark;
  assign abort_evt = (st_start || st_wait) && sector_mark;
  assign adv       = st_wait && fld_done && !last_rec && !sector_mark;
  assign fin       = st_wait && fld_done && last_rec && !sector_mark;

  sws_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .abort_evt(abort_evt),
    .adv      (adv),
    .fin      (fin),
    .st_start (st_start),
    .st_wait  (st_wait),
    .st_idle  (st_idle)
  );

  sws_rec_sel #(.NREC(NUM_REC)) u_rec (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .adv     (adv),
    .idx     (rec_idx),
    .last_rec(last_rec)
  );

  sws_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .abort_evt  (abort_evt),
    .fin        (fin),
    .write_gate (write_gate),
    .overrun    (overrun),
    .sector_done(sector_done)
  );

  assign cur_rec   = rec_e'(rec_idx);
  assign fld_start = st_start;
  assign fld_abort = abort_evt;
  assign fld_kind  = cur_rec;
  assign fld_words = LEN_W'(rec_len(cur_rec, HDR_WORDS, LBL_WORDS, DAT_WORDS));

endmodule

// File: rtl/sws_chk.sv
module sws_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic       abort_evt,
  input logic       fin,
  input logic       fld_start,
  input logic [1:0] fld_kind,
  input logic       write_gate,
  input logic       overrun,
  input logic       sector_done
);

  assert_gate_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> write_gate);

  assert_first_header_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (fld_start && fld_kind == 2'd0));

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fld_start |=> !fld_start);

  assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fld_start |-> write_gate);

  assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (!write_gate && sector_done));

  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!write_gate && overrun && !sector_done));

  assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !overrun);

  assert_ovr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !accept) |=> overrun);

  assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (write_gate && !abort_evt && !fin) |=> write_gate);

endmodule

bind sector_write_seq sws_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .abort_evt  (abort_evt),
  .fin        (fin),
  .fld_start  (fld_start),
  .fld_kind   (fld_kind),
  .write_gate (write_gate),
  .overrun    (overrun),
  .sector_done(sector_done)
);

// File: tb/sim_sector_write_seq.sv
module sim_sector_write_seq;

  localparam int CLK_PERIOD = 10;
  localparam int LBL = 5;
  localparam int LW = 9;
  localparam int NVEC = 7;
  // Vector table: field latency, sector-mark offset (0 = none), hold request.
  localparam int VEC_LAT [NVEC] = '{1, 3, 7, 4, 2, 5, 3};
  localparam int VEC_MARK[NVEC] = '{0, 0, 0, 6, 9, 1, 0};
  localparam int VEC_HOLD[NVEC] = '{0, 0, 0, 0, 0, 0, 1};

  logic clk = 0, rst_n = 0, wr_req = 0, sector_mark = 0;
  logic fld_done, fld_start, fld_abort, write_gate, overrun, sector_done;
  logic [1:0] fld_kind;
  logic [LW-1:0] fld_words;

  int checks = 0, errors = 0, cyc = 0, lat = 1, cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_write_seq #(.LBL_WORDS(LBL)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .sector_mark(sector_mark),
    .fld_done(fld_done), .fld_start(fld_start), .fld_abort(fld_abort),
    .fld_kind(fld_kind), .fld_words(fld_words), .write_gate(write_gate),
    .overrun(overrun), .sector_done(sector_done)
  );

  // Behavioural field writer: done pulse L cycles after a start.
  always_ff @(posedge clk) begin
    if (!rst_n || fld_abort) cnt <= 0;
    else if (fld_start)      cnt <= lat;
    else if (cnt != 0)       cnt <= cnt - 1;
  end
  assign fld_done = (cnt == 1);

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int want_words(int k);
    if (k == 0) return 2;
    if (k == 1) return LBL;
    return 256;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      summary();
    end
  end

  task automatic run_sector(int l, int m, int hold);
    int total, high, starts, aborts, exp_hi, exp_st;
    bit kind_ok, words_ok;
    lat = l;
    total = 3 * (l + 1);
    high = 0; starts = 0; aborts = 0; kind_ok = 1; words_ok = 1;
    @(negedge clk);
    wr_req = 1; sector_mark = 1;
    for (int c = 1; c < 2000; c++) begin
      @(negedge clk);
      if (c == 1) check(overrun == 0, "R8 overrun clear on accept", overrun, 0);
      if (!write_gate) break;
      high++;
      wr_req = (hold != 0);
      sector_mark = (c == m);
      #1;
      if (fld_start) begin
        if (fld_kind != starts[1:0]) kind_ok = 0;
        if (int'(fld_words) != want_words(starts)) words_ok = 0;
        starts++;
      end
      if (fld_abort) aborts++;
    end
    wr_req = 0; sector_mark = 0;
    exp_hi = (m != 0) ? m : total;
    exp_st = 0;
    for (int j = 0; j < 3; j++) if (m == 0 || 1 + j * (l + 1) <= m) exp_st++;
    check(high == exp_hi, (m != 0) ? "R7 gate cycles on abort" :
          (hold != 0) ? "R9 gate cycles with held request" : "R6 gate cycles",
          high, exp_hi);
    check(starts == exp_st, "R3/R5 start count", starts, exp_st);
    check(kind_ok, "R3 record order on fld_kind", kind_ok, 1);
    check(words_ok, "R4 fld_words per record", words_ok, 1);
    check(overrun == (m != 0), "R7 overrun flag", overrun, m != 0);
    check(sector_done == (m == 0), "R6 sector_done pulse", sector_done, m == 0);
    check(aborts == (m != 0 ? 1 : 0), "R7 fld_abort pulses", aborts, m != 0);
    @(negedge clk);
    check(sector_done == 0, "R6 sector_done one cycle", sector_done, 0);
    check(overrun == (m != 0), "R8 overrun holds", overrun, m != 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!write_gate && !overrun && !sector_done && !fld_start && !fld_abort,
          "R1 reset outputs", write_gate, 0);
    rst_n = 1;
    for (int v = 0; v < NVEC; v++) begin
      run_sector(VEC_LAT[v], VEC_MARK[v], VEC_HOLD[v]);
      repeat (2) @(negedge clk);
    end
    // R2: request without a sector mark is ignored.
    wr_req = 1;
    repeat (4) @(negedge clk);
    check(write_gate == 0, "R2 request without mark", write_gate, 0);
    wr_req = 0; sector_mark = 1;
    @(negedge clk);
    sector_mark = 0;
    @(negedge clk);
    check(write_gate == 0, "R2 mark without request", write_gate, 0);
    // R8: overrun from an abort, then cleared by a normal sector.
    run_sector(2, 3, 0);
    check(overrun == 1, "R8 overrun set before next request", overrun, 1);
    run_sector(1, 0, 0);
    check(overrun == 0, "R8 overrun cleared", overrun, 0);
    summary();
  end

endmodule